// File: doc/BRIEF.md
# Lane Alignment Sequence Parser

This block sits on the receive side of one lane of a serial converter link. It takes one decoded character per clock together with the link state, and follows the alignment sequence that the transmitter sends between code-group synchronisation and user data. That sequence is four multiframes long. The multiframe length in octets is an input. The block checks that each multiframe opens with the start control character and closes with the end control character, and that neither appears anywhere else.

While the second multiframe passes, the block captures the link configuration octets and unpacks them into a packed configuration record. On the closing character of that multiframe it checks the received checksum against the fields. It raises sticky error, checksum and unexpected-character flags, and it asserts a finished flag once the link enters data with a clean, complete sequence. A return of the link state to INIT clears all status and restarts the position tracking.

Top module: `lane_align_parser`

## Requirements
- R1: Every output is a register that reflects the character presented on the previous clock. With rstN low, or on the clock after a character presented with linkState = 0 (INIT), finished, linkErr, wrongChk, unexpChar and cfgValid are 0, and the multiframe position restarts.
- R2: linkState encodes 0 = INIT, 1 = SYNC, 2 = ALIGN, 3 = DATA. Characters are examined only in ALIGN. In SYNC, characters are ignored, including control 0xBC and the start and end control characters.
- R3: The start character is charIsCtrl = 1 with charVal = 0x1C. If it appears in ALIGN at any position other than position 0 of a multiframe, linkErr and unexpChar are 1 on the next clock. The same value without the control flag is plain data.
- R4: The end character is charIsCtrl = 1 with charVal = 0x7C. If it appears in ALIGN at any position other than the last one (mfOctets − 1) of a multiframe, linkErr and unexpChar are 1 on the next clock.
- R5: Positions 1 to 14 of the second multiframe (index 1) are octets 0 to 13 of the configuration, and cfgRecord packs the fields MSB first in this order: devId = o0; adjCount = o1[7:4]; bankId = o1[3:0]; adjDir = o2[6]; phaseAdj = o2[5]; laneId = o2[4:0]; scramble = o3[7]; laneCnt = o3[4:0]; octPerFrame = o4; framesPerMf = o5[4:0]; convCnt = o6; ctrlBits = o7[7:6]; resolution = o7[4:0]; subclassVer = o8[7:5]; sampleBits = o8[4:0]; version = o9[7:5]; samplesPerConv = o9[4:0]; highDensity = o10[7]; ctrlWords = o10[4:0]; res1 = o11; res2 = o12; checkSum = o13.
- R6: cfgValid rises on the clock after the last character of the second multiframe. From then on, cfgRecord and cfgValid hold through the rest of ALIGN and through DATA until INIT.
- R7: The expected checksum is the sum modulo 256 of the nineteen fields from devId to ctrlWords (res1 and res2 are excluded). If it differs from checkSum, linkErr and wrongChk are 1 on the clock after the second multiframe closes, and unexpChar stays 0.
- R8: Once set, linkErr, wrongChk and unexpChar stay set in every state until a character is presented with linkState = INIT.
- R9: When all four multiframes have been received with no error, finished is 1 on the clock after each DATA character.
- R10: A DATA character presented before four complete multiframes sets linkErr, and finished stays 0.
- R11: A character in ALIGN with charDispErr or charCodeErr set raises linkErr on the next clock, but neither wrongChk nor unexpChar.
- R12: The multiframe length is taken from mfOctets, which must be at least 16. Characters in the second multiframe after position 14 are not captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rstN | input | 1 | Asynchronous reset, active low |
| linkState | input | 2 | Link state: 0 INIT, 1 SYNC, 2 ALIGN, 3 DATA |
| charIsCtrl | input | 1 | Character is a control character |
| charDispErr | input | 1 | Running-disparity error on this character |
| charCodeErr | input | 1 | Invalid code group on this character |
| charVal | input | 8 | Decoded character value |
| mfOctets | input | MF_LEN_W | Multiframe length in octets |
| cfgRecord | output | 103 | Unpacked configuration record |
| cfgValid | output | 1 | Configuration record captured |
| finished | output | 1 | Sequence complete and clean while in DATA |
| linkErr | output | 1 | Any sequence error (sticky) |
| wrongChk | output | 1 | Configuration checksum mismatch (sticky) |
| unexpChar | output | 1 | Misplaced start or end character (sticky) |

## Verification
The bench builds the block with MF_LEN_W = 9 and NUM_MF = 4. It drives mfOctets at 16 and at 20. A length of 16 is the tightest case: the checksum octet arrives on the clock just before the closing end character, so the comparison sees a checksum captured only one cycle earlier. A length of 20 puts filler octets after the checksum inside the configuration multiframe, which shows that capture stops at position 14 and that the counters wrap at a length other than the minimum. Two different configuration records, one per length, exercise the bit unpacking and the modulo-256 wrap of the sum.

// File: rtl/lane_align_pkg.sv
package lane_align_pkg;

  typedef enum logic [1:0] {
    LS_RESET = 2'd0,
    LS_SYNC  = 2'd1,
    LS_ALIGN = 2'd2,
    LS_DATA  = 2'd3
  } link_state_e;

  localparam logic [7:0] CH_START = 8'h1C;
  localparam logic [7:0] CH_END   = 8'h7C;

  localparam int CFG_OCTETS = 14;
  localparam int IDX_W      = $clog2(CFG_OCTETS);
  localparam int CFG_MF     = 1;

  typedef struct packed {
    logic [7:0] devId;
    logic [3:0] adjCount;
    logic [3:0] bankId;
    logic       adjDir;
    logic       phaseAdj;
    logic [4:0] laneId;
    logic       scramble;
    logic [4:0] laneCnt;
    logic [7:0] octPerFrame;
    logic [4:0] framesPerMf;
    logic [7:0] convCnt;
    logic [1:0] ctrlBits;
    logic [4:0] resolution;
    logic [2:0] subclassVer;
    logic [4:0] sampleBits;
    logic [2:0] version;
    logic [4:0] samplesPerConv;
    logic       highDensity;
    logic [4:0] ctrlWords;
    logic [7:0] res1;
    logic [7:0] res2;
    logic [7:0] checkSum;
  } cfg_t;

  localparam int CFG_BITS = $bits(cfg_t);

  typedef struct packed {
    logic             clear;
    logic             capEn;
    logic [IDX_W-1:0] capIdx;
  } strobe_t;

endpackage

// File: rtl/lane_align_ctrl.sv
module lane_align_ctrl
  import lane_align_pkg::*;
#(
  parameter int MF_LEN_W = 9,
  parameter int NUM_MF   = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [1:0]          linkState,
  input  logic                isCtrl,
  input  logic                dispErr,
  input  logic                codeErr,
  input  logic [7:0]          charVal,
  input  logic [MF_LEN_W-1:0] mfOctets,
  input  logic                chkMismatch,
  output strobe_t             stb,
  output logic                finished,
  output logic                errAny,
  output logic                wrongChk,
  output logic                unexpChar,
  output logic                cfgValid
);

  localparam int MF_W = (NUM_MF > 1) ? $clog2(NUM_MF) : 1;

  link_state_e         st;
  logic [MF_LEN_W-1:0] pos;
  logic [MF_LEN_W-1:0] lastPos;
  logic [MF_W-1:0]     mfIdx;
  logic                seqDone;

  logic isStart, isEnd, atFirst, atLast, active;
  logic misplaced, decodeBad, closeCfg, earlyData, inCfgMf;

  always_comb begin
    st        = link_state_e'(linkState);
    lastPos   = mfOctets - MF_LEN_W'(1);
    isStart   = isCtrl && (charVal == CH_START);
    isEnd     = isCtrl && (charVal == CH_END);
    atFirst   = (pos == '0);
    atLast    = (pos == lastPos);
    active    = (st == LS_ALIGN) && !seqDone;
    inCfgMf   = (mfIdx == MF_W'(CFG_MF));
    misplaced = active && ((isStart && !atFirst) || (isEnd && !atLast));
    decodeBad = active && (dispErr || codeErr);
    closeCfg  = active && atLast && inCfgMf;
    earlyData = (st == LS_DATA) && !seqDone;

    stb.clear  = (st == LS_RESET);
    stb.capEn  = active && inCfgMf && !atFirst &&
                 (pos <= MF_LEN_W'(CFG_OCTETS));
    stb.capIdx = IDX_W'(pos - MF_LEN_W'(1));
  end

  // Position tracking across the multiframes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pos     <= '0;
      mfIdx   <= '0;
      seqDone <= 1'b0;
    end else if (st == LS_RESET) begin
      pos     <= '0;
      mfIdx   <= '0;
      seqDone <= 1'b0;
    end else if (active) begin
      if (atLast) begin
        pos <= '0;
        if (mfIdx == MF_W'(NUM_MF - 1)) seqDone <= 1'b1;
        else                            mfIdx   <= mfIdx + MF_W'(1);
      end else begin
        pos <= pos + MF_LEN_W'(1);
      end
    end
  end

  // Sticky status flags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errAny    <= 1'b0;
      wrongChk  <= 1'b0;
      unexpChar <= 1'b0;
      cfgValid  <= 1'b0;
      finished  <= 1'b0;
    end else if (st == LS_RESET) begin
      errAny    <= 1'b0;
      wrongChk  <= 1'b0;
      unexpChar <= 1'b0;
      cfgValid  <= 1'b0;
      finished  <= 1'b0;
    end else begin
      if (misplaced) begin
        errAny    <= 1'b1;
        unexpChar <= 1'b1;
      end
      if (decodeBad || earlyData) errAny <= 1'b1;
      if (closeCfg) begin
        cfgValid <= 1'b1;
        if (chkMismatch) begin
          errAny   <= 1'b1;
          wrongChk <= 1'b1;
        end
      end
      finished <= (st == LS_DATA) && seqDone && !errAny;
    end
  end

endmodule

// File: rtl/lane_align_dpath.sv
module lane_align_dpath
  import lane_align_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  strobe_t    stb,
  input  logic [7:0] charVal,
  output cfg_t       cfgOut,
  output logic       chkMismatch
);

  cfg_t       cfgReg;
  logic [7:0] fieldSum;

  // Capture octets straight into their unpacked fields
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgReg <= '0;
    end else if (stb.clear) begin
      cfgReg <= '0;
    end else if (stb.capEn) begin
      case (stb.capIdx)
        4'd0:  cfgReg.devId <= charVal;
        4'd1:  begin
                 cfgReg.adjCount <= charVal[7:4];
                 cfgReg.bankId   <= charVal[3:0];
               end
        4'd2:  begin
                 cfgReg.adjDir   <= charVal[6];
                 cfgReg.phaseAdj <= charVal[5];
                 cfgReg.laneId   <= charVal[4:0];
               end
        4'd3:  begin
                 cfgReg.scramble <= charVal[7];
                 cfgReg.laneCnt  <= charVal[4:0];
               end
        4'd4:  cfgReg.octPerFrame <= charVal;
        4'd5:  cfgReg.framesPerMf <= charVal[4:0];
        4'd6:  cfgReg.convCnt     <= charVal;
        4'd7:  begin
                 cfgReg.ctrlBits   <= charVal[7:6];
                 cfgReg.resolution <= charVal[4:0];
               end
        4'd8:  begin
                 cfgReg.subclassVer <= charVal[7:5];
                 cfgReg.sampleBits  <= charVal[4:0];
               end
        4'd9:  begin
                 cfgReg.version        <= charVal[7:5];
                 cfgReg.samplesPerConv <= charVal[4:0];
               end
        4'd10: begin
                 cfgReg.highDensity <= charVal[7];
                 cfgReg.ctrlWords   <= charVal[4:0];
               end
        4'd11: cfgReg.res1     <= charVal;
        4'd12: cfgReg.res2     <= charVal;
        4'd13: cfgReg.checkSum <= charVal;
        default: ;
      endcase
    end
  end

  // Modulo-256 sum of the configuration fields, reserved octets excluded
  always_comb begin
    fieldSum = cfgReg.devId + 8'(cfgReg.adjCount) + 8'(cfgReg.bankId)
             + 8'(cfgReg.adjDir) + 8'(cfgReg.phaseAdj) + 8'(cfgReg.laneId)
             + 8'(cfgReg.scramble) + 8'(cfgReg.laneCnt) + cfgReg.octPerFrame
             + 8'(cfgReg.framesPerMf) + cfgReg.convCnt + 8'(cfgReg.ctrlBits)
             + 8'(cfgReg.resolution) + 8'(cfgReg.subclassVer)
             + 8'(cfgReg.sampleBits) + 8'(cfgReg.version)
             + 8'(cfgReg.samplesPerConv) + 8'(cfgReg.highDensity)
             + 8'(cfgReg.ctrlWords);
    chkMismatch = (fieldSum != cfgReg.checkSum);
    cfgOut      = cfgReg;
  end

endmodule

// File: rtl/lane_align_parser.sv
module lane_align_parser
  import lane_align_pkg::*;
#(
  parameter int MF_LEN_W = 9,
  parameter int NUM_MF   = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [1:0]          linkState,
  input  logic                charIsCtrl,
  input  logic                charDispErr,
  input  logic                charCodeErr,
  input  logic [7:0]          charVal,
  input  logic [MF_LEN_W-1:0] mfOctets,
  output logic [CFG_BITS-1:0] cfgRecord,
  output logic                cfgValid,
  output logic                finished,
  output logic                linkErr,
  output logic                wrongChk,
  output logic                unexpChar
);

  strobe_t stb;
  cfg_t    cfgNow;
  logic    chkMismatch;

  lane_align_ctrl #(
    .MF_LEN_W (MF_LEN_W),
    .NUM_MF   (NUM_MF)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .linkState   (linkState),
    .isCtrl      (charIsCtrl),
    .dispErr     (charDispErr),
    .codeErr     (charCodeErr),
    .charVal     (charVal),
    .mfOctets    (mfOctets),
    .chkMismatch (chkMismatch),
    .stb         (stb),
    .finished    (finished),
    .errAny      (linkErr),
    .wrongChk    (wrongChk),
    .unexpChar   (unexpChar),
    .cfgValid    (cfgValid)
  );

  lane_align_dpath u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .charVal     (charVal),
    .cfgOut      (cfgNow),
    .chkMismatch (chkMismatch)
  );

  assign cfgRecord = cfgNow;

endmodule

// File: rtl/lane_align_parser_chk.sv
module lane_align_parser_chk
  import lane_align_pkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic [1:0]          linkState,
  input logic [CFG_BITS-1:0] cfgRecord,
  input logic                cfgValid,
  input logic                finished,
  input logic                linkErr,
  input logic                wrongChk,
  input logic                unexpChar
);

  p_init_clear_r1: assert property (@(posedge clk) disable iff (!rstN)
    (linkState == 2'd0) |=> (!linkErr && !finished && !cfgValid && !wrongChk && !unexpChar));

  p_sync_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    (linkState == 2'd1 && !linkErr) |=> !linkErr);

  p_unexp_flags_err_r3: assert property (@(posedge clk) disable iff (!rstN)
    unexpChar |-> linkErr);

  p_cfg_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (cfgValid && linkState != 2'd0) |=> (cfgValid && $stable(cfgRecord)));

  p_chk_flags_err_r7: assert property (@(posedge clk) disable iff (!rstN)
    wrongChk |-> linkErr);

  p_sticky_err_r8: assert property (@(posedge clk) disable iff (!rstN)
    (linkErr && linkState != 2'd0) |=> linkErr);

  p_finish_clean_r9: assert property (@(posedge clk) disable iff (!rstN)
    finished |-> !linkErr);

endmodule

bind lane_align_parser lane_align_parser_chk u_chk (.*);

// File: tb/test_lane_align_parser.sv
`timescale 1ns/1ps
module test_lane_align_parser;
  import lane_align_pkg::*;

  localparam int MF_LEN_W = 9;

  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic [1:0]          linkState = 2'd0;
  logic                charIsCtrl = 1'b0, charDispErr = 1'b0, charCodeErr = 1'b0;
  logic [7:0]          charVal = 8'h00;
  logic [MF_LEN_W-1:0] mfOctets = 9'd16;
  logic [CFG_BITS-1:0] cfgRecord;
  logic cfgValid, finished, linkErr, wrongChk, unexpChar;

  lane_align_parser #(.MF_LEN_W(MF_LEN_W), .NUM_MF(4)) i_lane_align_parser (
    .clk(clk), .rstN(rstN), .linkState(linkState), .charIsCtrl(charIsCtrl),
    .charDispErr(charDispErr), .charCodeErr(charCodeErr), .charVal(charVal),
    .mfOctets(mfOctets), .cfgRecord(cfgRecord), .cfgValid(cfgValid),
    .finished(finished), .linkErr(linkErr), .wrongChk(wrongChk),
    .unexpChar(unexpChar));

  always #10 clk = ~clk;   // 50 MHz

  typedef struct {
    logic [4:0] flags;     // {finished, linkErr, wrongChk, unexpChar, cfgValid}
    cfg_t       cfg;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   nCmp = 0, nBad = 0;
  bit   runOver = 0;

  bit   sErr, sChk, sUnx, sCv, sDone;
  cfg_t sCfg;

  function automatic logic [7:0] octOf(cfg_t c, int i);
    case (i)
      0:  return c.devId;
      1:  return {c.adjCount, c.bankId};
      2:  return {1'b0, c.adjDir, c.phaseAdj, c.laneId};
      3:  return {c.scramble, 2'b00, c.laneCnt};
      4:  return c.octPerFrame;
      5:  return {3'b000, c.framesPerMf};
      6:  return c.convCnt;
      7:  return {c.ctrlBits, 1'b0, c.resolution};
      8:  return {c.subclassVer, c.sampleBits};
      9:  return {c.version, c.samplesPerConv};
      10: return {c.highDensity, 2'b00, c.ctrlWords};
      11: return c.res1;
      12: return c.res2;
      default: return c.checkSum;
    endcase
  endfunction

  function automatic logic [7:0] sumOf(cfg_t c);
    int s;
    s = c.devId + c.adjCount + c.bankId + c.adjDir + c.phaseAdj + c.laneId
      + c.scramble + c.laneCnt + c.octPerFrame + c.framesPerMf + c.convCnt
      + c.ctrlBits + c.resolution + c.subclassVer + c.sampleBits + c.version
      + c.samplesPerConv + c.highDensity + c.ctrlWords;
    return 8'(s % 256);
  endfunction

  task automatic drive(input logic [1:0] st, input logic k, input logic [7:0] v,
                       input logic de, input logic ce);
    @(negedge clk);
    linkState = st; charIsCtrl = k; charVal = v; charDispErr = de; charCodeErr = ce;
  endtask

  task automatic pushExp(input logic fin, input string tag);
    exp_t e;
    e.flags = {fin, sErr, sChk, sUnx, sCv};
    e.cfg   = sCfg;
    e.tag   = tag;
    q.push_back(e);
  endtask

  // R1: INIT clears everything
  task automatic goInit(input string tag);
    drive(2'd0, 1'b0, 8'h00, 1'b0, 1'b0);
    sErr = 0; sChk = 0; sUnx = 0; sCv = 0; sDone = 0;
    pushExp(1'b0, tag);
  endtask

  // R2: SYNC characters are ignored, including start and end characters
  task automatic syncChars(input int n);
    for (int i = 0; i < n; i++) begin
      drive(2'd1, 1'b1, 8'hBC, 1'b0, 1'b0);
      pushExp(1'b0, "R2");
    end
    drive(2'd1, 1'b1, CH_START, 1'b0, 1'b0);
    pushExp(1'b0, "R2");
    drive(2'd1, 1'b1, CH_END, 1'b0, 1'b0);
    pushExp(1'b0, "R2");
  endtask

  // fKind: 0 none, 1 start char, 2 end char, 3 disparity error, 4 code error
  task automatic playSeq(input int len, input int nMf, input int fMf, input int fPos,
                         input int fKind, input logic [7:0] chkByte, input cfg_t c,
                         input string tag);
    logic [7:0] goodSum;
    goodSum = sumOf(c);
    sCfg = c;
    sCfg.checkSum = chkByte;
    for (int m = 0; m < nMf; m++) begin
      for (int p = 0; p < len; p++) begin
        logic k, de, ce;
        logic [7:0] v;
        bit hit;
        k = 0; de = 0; ce = 0;
        v = 8'((p * 7 + m) % 256);
        if (p == 0) begin k = 1; v = CH_START; end
        else if (p == len - 1) begin k = 1; v = CH_END; end
        else if (m == 1 && p <= 14) v = (p == 14) ? chkByte : octOf(c, p - 1);
        hit = (m == fMf) && (p == fPos);
        if (hit) begin
          case (fKind)
            1: begin k = 1; v = CH_START; end
            2: begin k = 1; v = CH_END; end
            3: de = 1;
            4: ce = 1;
            default: ;
          endcase
        end
        drive(2'd2, k, v, de, ce);
        if (hit && (fKind == 1 || fKind == 2)) begin sErr = 1; sUnx = 1; end
        if (hit && (fKind == 3 || fKind == 4)) sErr = 1;
        if (m == 1 && p == len - 1) begin
          sCv = 1;
          if (chkByte != goodSum) begin sErr = 1; sChk = 1; end
        end
        if (m == 3 && p == len - 1) sDone = 1;
        pushExp(1'b0, tag);
      end
    end
  endtask

  // R9 / R10: DATA characters
  task automatic dataChars(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      drive(2'd3, 1'b0, 8'(i + 1), 1'b0, 1'b0);
      if (!sDone) sErr = 1;
      pushExp(sDone && !sErr, tag);
    end
  endtask

  // Scoreboard monitor
  always @(posedge clk) begin
    #5;
    if (q.size() > 0) begin
      exp_t e;
      logic [4:0] act;
      e = q.pop_front();
      act = {finished, linkErr, wrongChk, unexpChar, cfgValid};
      nCmp++;
      if (act !== e.flags || (e.flags[0] && cfgRecord !== e.cfg)) begin
        nBad++;
        $display("FAIL %s: flags act=%b exp=%b cfg act=%h exp=%h",
                 e.tag, act, e.flags, cfgRecord, e.cfg);
      end
    end
  end

  task automatic finishRun();
    if (!runOver) begin
      runOver = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  endtask

  initial begin
    #(20ns * 200000);
    nCmp++; nBad++;
    $display("FAIL watchdog: act=running exp=done");
    finishRun();
  end

  initial begin
    cfg_t cfgA, cfgB;
    cfgA = '0;
    cfgA.devId = 8'hAA; cfgA.adjCount = 4'h7; cfgA.bankId = 4'hE; cfgA.adjDir = 1;
    cfgA.phaseAdj = 0; cfgA.laneId = 5'd10; cfgA.scramble = 1; cfgA.laneCnt = 5'd30;
    cfgA.octPerFrame = 8'hCC; cfgA.framesPerMf = 5'd31; cfgA.convCnt = 8'h33;
    cfgA.ctrlBits = 2'd2; cfgA.resolution = 5'd3; cfgA.subclassVer = 3'd1;
    cfgA.sampleBits = 5'd29; cfgA.res1 = 8'hFF; cfgA.res2 = 8'h00;
    cfgA.checkSum = sumOf(cfgA);
    cfgB = '0;
    cfgB.devId = 8'h13; cfgB.adjCount = 4'h2; cfgB.bankId = 4'h5; cfgB.phaseAdj = 1;
    cfgB.laneId = 5'd3; cfgB.laneCnt = 5'd1; cfgB.octPerFrame = 8'h02;
    cfgB.framesPerMf = 5'd31; cfgB.convCnt = 8'h01; cfgB.resolution = 5'd15;
    cfgB.subclassVer = 3'd1; cfgB.sampleBits = 5'd15; cfgB.version = 3'd1;
    cfgB.highDensity = 1; cfgB.res1 = 8'h5A; cfgB.res2 = 8'hA5;
    cfgB.checkSum = sumOf(cfgB);

    repeat (3) @(negedge clk);
    // R1: reset state
    nCmp++;
    if ({finished, linkErr, wrongChk, unexpChar, cfgValid} !== 5'b0) begin
      nBad++;
      $display("FAIL R1 reset: act=%b exp=00000",
               {finished, linkErr, wrongChk, unexpChar, cfgValid});
    end
    rstN = 1'b1;

    // Clean sequence at length 16 (R5, R6, R9)
    goInit("R1");
    syncChars(3);
    playSeq(16, 4, -1, -1, 0, cfgA.checkSum, cfgA, "R5");
    dataChars(3, "R9");
    goInit("R1");

    // Misplaced start character, then stickiness (R3, R8)
    syncChars(1);
    playSeq(16, 4, 0, 3, 1, cfgA.checkSum, cfgA, "R3");
    dataChars(2, "R8");
    goInit("R8");

    // Misplaced end character (R4)
    playSeq(16, 4, 0, 3, 2, cfgA.checkSum, cfgA, "R4");
    goInit("R1");

    // Bad checksum (R7), no finish afterwards
    playSeq(16, 4, -1, -1, 0, cfgA.checkSum ^ 8'h01, cfgA, "R7");
    dataChars(2, "R9");
    goInit("R1");

    // Early DATA after two multiframes (R10); record held (R6)
    playSeq(16, 2, -1, -1, 0, cfgA.checkSum, cfgA, "R6");
    dataChars(3, "R10");
    goInit("R1");

    // Decode errors (R11)
    playSeq(16, 4, 2, 5, 3, cfgA.checkSum, cfgA, "R11");
    dataChars(1, "R11");
    goInit("R1");
    playSeq(16, 4, 3, 7, 4, cfgA.checkSum, cfgA, "R11");
    goInit("R1");

    // Longer multiframe (R12)
    mfOctets = 9'd20;
    goInit("R12");
    playSeq(20, 4, -1, -1, 0, cfgB.checkSum, cfgB, "R12");
    dataChars(2, "R12");
    goInit("R1");

    repeat (4) @(negedge clk);
    finishRun();
  end

endmodule